// File: doc/BRIEF.md
# Bitfield Move and Extract Unit

This unit is an integer datapath slice for a 64-bit pipeline. It performs three bitfield-move operations and one two-register extract. All three bitfield moves are driven by two small immediates: a rotate amount and a top-bit index. The source operand is rotated right by the rotate amount. It is then gated by a field mask built from the two immediates, and the three variants differ only in what lands outside that mask:

- Insert keeps the old destination bits.
- Zero-move clears them.
- Sign-move fills everything above the field with the source bit selected by the top-bit index.

The extract operation is a funnel shift. The first operand is concatenated above the second, and a window of operand width is taken at the immediate offset.

Each operation runs at 64-bit or 32-bit operand width. In 32-bit mode every rotate, mask and shift works on the low half, and the upper half of the result is zero. The combinational result is captured in one output register. A valid strobe launches an operation, and the result appears with its own valid flag on the next clock.

Top module: `bitfield_move_unit`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `result` is all zeros.
- R2: `outValid` equals the value `inValid` had at the previous rising clock edge. `result` is loaded only on an edge where `inValid` is 1 and holds its value otherwise.
- R3: Let W be the operand width (64 when `wide`=1, 32 when `wide`=0). When `immR` <= `immS`, the field mask is `immS-immR+1` ones starting at bit 0. The span length is `immS-immR+1`.
- R4: When `immR` > `immS`, the field mask is `immS+1` low ones rotated right by `immR` within W bits. The span length is `immS-immR+W+1`.
- R5: `opSel`=2'b00 (insert) returns the rotated `srcA` in the masked bits and `srcB` in every other bit below W.
- R6: `opSel`=2'b01 (zero-move) returns the rotated `srcA` in the masked bits and zero elsewhere.
- R7: `opSel`=2'b10 (sign-move) returns the rotated, masked `srcA`, ORed with ones at every bit position at or above the span length and below W. The fill applies only when bit `immS` of `srcA` is 1.
- R8: `opSel`=2'b11 (extract) returns `srcB` when `immR` is 0. Otherwise it returns (`srcA` << (W-`immR`)) | (`srcB` >> `immR`), all within W bits.
- R9: With `wide`=0, bits 63:32 of both sources are ignored, each immediate is taken modulo 32, and bits 63:32 of the result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Launch an operation this cycle |
| opSel | input | 2 | 00 insert, 01 zero-move, 10 sign-move, 11 extract |
| wide | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands |
| srcA | input | 64 | Bitfield source; upper word for extract |
| srcB | input | 64 | Old destination for insert; lower word for extract |
| immR | input | 6 | Rotate amount, or shift amount for extract |
| immS | input | 6 | Top-bit index of the field |
| outValid | output | 1 | Result is valid |
| result | output | 64 | Registered result word |

## Verification
The unit holds no state beyond the output register, so any internal fault shows at the ports one clock after the operation is launched. Such faults include a wrong mask run length, a missed wrap rotation, a misplaced fill boundary or a wrong funnel offset. A fault of this kind shows as wrong bits in `result` on the cycle that `outValid` is high. The corner immediates are where an off-by-one in the mask or span length first changes a bit: equal immediates, a zero rotate, a top index of W-1, and a wrap by exactly one. A fault in the load enable shows as a change in `result` on a cycle after `inValid` was low.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

  typedef enum logic [1:0] {
    OP_INSERT  = 2'b00,
    OP_ZMOVE   = 2'b01,
    OP_SMOVE   = 2'b10,
    OP_EXTRACT = 2'b11
  } bfOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wide;      // 64-bit operand width
    logic keepOld;   // merge old destination outside the field
    logic fillSign;  // replicate the field's top bit upward
    logic funnel;    // two-operand extract instead of a bitfield move
  } bfStrobe_t;

endpackage

// File: rtl/bfm_ctrl.sv
module bfm_ctrl
  import bfm_pkg::*;
#(
  parameter int IMM_W = 6
) (
  input  logic [1:0]       opSel,
  input  logic             wide,
  input  logic [IMM_W-1:0] immR,
  input  logic [IMM_W-1:0] immS,
  output bfStrobe_t        stb,
  output logic [IMM_W-1:0] effR,
  output logic [IMM_W-1:0] effS
);

  always_comb begin
    stb          = '0;
    stb.wide     = wide;
    unique case (bfOp_e'(opSel))
      OP_INSERT:  stb.keepOld  = 1'b1;
      OP_ZMOVE:   ;
      OP_SMOVE:   stb.fillSign = 1'b1;
      OP_EXTRACT: stb.funnel   = 1'b1;
      default:    ;
    endcase
  end

  // Narrow mode: immediates reduced modulo half the width.
  always_comb begin
    effR = immR;
    effS = immS;
    if (!wide) begin
      effR[IMM_W-1] = 1'b0;
      effS[IMM_W-1] = 1'b0;
    end
  end

  always_comb begin
    // R5
    strobe_excl_chk: assert ($onehot0({stb.keepOld, stb.fillSign, stb.funnel}));
  end

endmodule

// File: rtl/bfm_datapath.sv
module bfm_datapath
  import bfm_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF  = DATA_W / 2,
  localparam int IMM_W = $clog2(DATA_W),
  localparam int CNT_W = IMM_W + 2
) (
  input  bfStrobe_t         stb,
  input  logic [IMM_W-1:0]  effR,
  input  logic [IMM_W-1:0]  effS,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] dpOut
);

  function automatic logic [DATA_W-1:0] lowOnes(input logic [CNT_W-1:0] n);
    logic [DATA_W:0] t;
    t = ({{DATA_W{1'b0}}, 1'b1} << n) - (DATA_W+1)'(1);
    return t[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] rotRight(input logic [DATA_W-1:0] v,
                                                 input logic [IMM_W-1:0] amt,
                                                 input logic isWide);
    logic [2*DATA_W-1:0] dbl;
    logic [DATA_W-1:0]   res;
    if (isWide) begin
      dbl = {v, v} >> amt;
      res = dbl[DATA_W-1:0];
    end else begin
      dbl = {{DATA_W{1'b0}}, v[HALF-1:0], v[HALF-1:0]} >> amt;
      res = {{HALF{1'b0}}, dbl[HALF-1:0]};
    end
    return res;
  endfunction

  logic [DATA_W-1:0]   widthMask;
  logic [DATA_W-1:0]   aIn, bIn;
  logic [CNT_W-1:0]    widthVal, rNum, sNum, fieldLen;
  logic                nonWrap;
  logic [DATA_W-1:0]   fieldMask, rotSrc, picked, fill;
  logic                topBit;
  logic [2*DATA_W-1:0] funnelDbl;
  logic [DATA_W-1:0]   funnelRes;

  assign widthMask = stb.wide ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign aIn       = srcA & widthMask;
  assign bIn       = srcB & widthMask;

  assign widthVal  = stb.wide ? CNT_W'(DATA_W) : CNT_W'(HALF);
  assign rNum      = CNT_W'(effR);
  assign sNum      = CNT_W'(effS);
  assign nonWrap   = (effR <= effS);

  // Span length: width of the low run whose complement forms the sign fill
  assign fieldLen  = nonWrap ? (sNum - rNum + CNT_W'(1))
                             : (widthVal + sNum - rNum + CNT_W'(1));

  assign fieldMask = nonWrap ? lowOnes(sNum - rNum + CNT_W'(1))
                             : rotRight(lowOnes(sNum + CNT_W'(1)), effR, stb.wide);

  assign rotSrc    = rotRight(aIn, effR, stb.wide);
  assign picked    = rotSrc & fieldMask;
  assign topBit    = aIn[effS];
  assign fill      = topBit ? (~lowOnes(fieldLen) & widthMask) : '0;

  always_comb begin
    if (stb.wide) begin
      funnelDbl = {aIn, bIn} >> effR;
      funnelRes = funnelDbl[DATA_W-1:0];
    end else begin
      funnelDbl = {{DATA_W{1'b0}}, aIn[HALF-1:0], bIn[HALF-1:0]} >> effR;
      funnelRes = {{HALF{1'b0}}, funnelDbl[HALF-1:0]};
    end
  end

  always_comb begin
    if (stb.funnel)        dpOut = funnelRes;
    else if (stb.keepOld)  dpOut = picked | (bIn & ~fieldMask);
    else if (stb.fillSign) dpOut = picked | fill;
    else                   dpOut = picked;
  end

  always_comb begin
    // R5
    if (stb.keepOld && !stb.funnel) begin
      insert_keep_chk: assert (((dpOut ^ bIn) & ~fieldMask) == '0);
    end
    // R6
    if (!stb.keepOld && !stb.fillSign && !stb.funnel) begin
      zmove_clear_chk: assert ((dpOut & ~fieldMask) == '0);
    end
    // R7
    if (stb.fillSign && topBit) begin
      smove_fill_chk: assert ((dpOut & fill) == fill);
    end
    // R9
    if (!stb.wide) begin
      narrow_upper_chk: assert (dpOut[DATA_W-1:HALF] == '0);
    end
  end

endmodule

// File: rtl/bitfield_move_unit.sv
module bitfield_move_unit
  import bfm_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int IMM_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic              wide,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  immR,
  input  logic [IMM_W-1:0]  immS,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  localparam int HALF = DATA_W / 2;

  bfStrobe_t         stb;
  logic [IMM_W-1:0]  effR, effS;
  logic [DATA_W-1:0] dpOut;

  bfm_ctrl #(.IMM_W(IMM_W)) uCtrl (
    .opSel (opSel),
    .wide  (wide),
    .immR  (immR),
    .immS  (immS),
    .stb   (stb),
    .effR  (effR),
    .effS  (effS)
  );

  bfm_datapath #(.DATA_W(DATA_W)) uDp (
    .stb   (stb),
    .effR  (effR),
    .effS  (effS),
    .srcA  (srcA),
    .srcB  (srcB),
    .dpOut (dpOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) result <= dpOut;
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
  // R9
  narrow_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !wide) |=> (result[DATA_W-1:HALF] == '0));

endmodule

// File: tb/sim_bitfield_move_unit.sv
`timescale 1ns/1ps
module sim_bitfield_move_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = '0;
  logic        wide = 1'b1;
  logic [63:0] srcA = '0, srcB = '0;
  logic [5:0]  immR = '0, immS = '0;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bitfield_move_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .wide(wide),
    .srcA(srcA), .srcB(srcB), .immR(immR), .immS(immS),
    .outValid(outValid), .result(result)
  );

  function automatic logic [63:0] refModel(int op, bit w, logic [63:0] a,
                                           logic [63:0] b, int r, int s);
    int W;
    int span;
    logic [63:0] rot, msk, res;
    W = w ? 64 : 32;
    if (!w) begin r = r % 32; s = s % 32; end
    rot = '0; msk = '0; res = '0;
    for (int i = 0; i < W; i++) rot[i] = a[(i + r) % W];
    if (r <= s) begin
      span = s - r;
      for (int i = 0; i < W; i++) msk[i] = (i <= s - r);
    end else begin
      span = s - r + W;
      for (int i = 0; i < W; i++) msk[i] = (((i + r) % W) <= s);
    end
    for (int i = 0; i < W; i++) begin
      case (op)
        0: res[i] = msk[i] ? rot[i] : b[i];
        1: res[i] = msk[i] & rot[i];
        2: res[i] = (msk[i] & rot[i]) | (a[s] && (i > span));
        default: res[i] = ((i + r) < W) ? b[i + r] : a[i + r - W];
      endcase
    end
    return res;
  endfunction

  function automatic string opReq(int op);
    case (op)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic runOp(string req, int op, bit w, logic [63:0] a, logic [63:0] b,
                       int r, int s, bit checkHold);
    logic [63:0] exp;
    exp = refModel(op, w, a, b, r, s);
    @(negedge clk);
    opSel = 2'(op); wide = w; srcA = a; srcB = b;
    immR = 6'(r); immS = 6'(s); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " result"}, result, exp);
    check("R2 valid", {63'd0, outValid}, 64'd1);
    if (checkHold) begin
      srcA = ~a; srcB = ~b;
      @(negedge clk);
      check("R2 hold", result, exp);
      check("R2 valid low", {63'd0, outValid}, 64'd0);
    end
  endtask

  initial begin
    int r0;
    r0 = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset result", result, 64'd0);
    check("R1 reset valid", {63'd0, outValid}, 64'd0);
    rstN = 1'b1;

    // R3 equal immediates and zero rotate
    runOp("R3", 1, 1, 64'hDEAD_BEEF_0123_4567, 64'h0, 7, 7, 1'b1);
    runOp("R3", 1, 1, 64'hDEAD_BEEF_0123_4567, 64'h0, 0, 15, 1'b0);
    runOp("R3", 1, 1, 64'hFFFF_0000_FFFF_0000, 64'h0, 0, 63, 1'b0);
    // R4 wrap masks
    runOp("R4", 1, 1, 64'h0123_4567_89AB_CDEF, 64'h0, 8, 7, 1'b0);
    runOp("R4", 1, 1, 64'h0123_4567_89AB_CDEF, 64'h0, 63, 0, 1'b0);
    // R5 insert
    runOp("R5", 0, 1, 64'h0000_0000_0000_00AB, 64'hFFFF_FFFF_FFFF_FFFF, 56, 7, 1'b1);
    runOp("R5", 0, 1, 64'h1234_5678_9ABC_DEF0, 64'h5555_5555_5555_5555, 4, 11, 1'b0);
    // R6
    runOp("R6", 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111, 60, 3, 1'b0);
    // R7 fill on and off
    runOp("R7", 2, 1, 64'h0000_0000_0000_0080, 64'h0, 0, 7, 1'b0);
    runOp("R7", 2, 1, 64'h0000_0000_0000_007F, 64'h0, 0, 7, 1'b0);
    runOp("R7", 2, 1, 64'h8000_0000_0000_0000, 64'h0, 1, 63, 1'b0);
    runOp("R7", 2, 1, 64'h0000_0000_0000_0001, 64'h0, 4, 0, 1'b0);
    // R8 extract
    runOp("R8", 3, 1, 64'hAAAA_AAAA_AAAA_AAAA, 64'h1234_5678_9ABC_DEF0, 0, 0, 1'b0);
    runOp("R8", 3, 1, 64'hAAAA_AAAA_AAAA_AAAA, 64'h1234_5678_9ABC_DEF0, 63, 0, 1'b0);
    runOp("R8", 3, 1, 64'h0F0F_0000_0000_00F0, 64'h1234_5678_9ABC_DEF0, 16, 0, 1'b0);
    // R9 narrow mode with dirty upper halves and oversize immediates
    runOp("R9", 0, 0, 64'hFFFF_FFFF_0000_00CD, 64'hAAAA_AAAA_1234_5678, 40, 39, 1'b1);
    runOp("R9", 2, 0, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0000, 1, 31, 1'b0);
    runOp("R9", 3, 0, 64'hFFFF_FFFF_1234_5678, 64'hEEEE_EEEE_9ABC_DEF0, 31, 0, 1'b0);
    runOp("R9", 3, 0, 64'h1, 64'hEEEE_EEEE_9ABC_DEF0, 32, 0, 1'b0);
    runOp("R9", 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 31, 30, 1'b0);

    // Random sweep over all opcodes and widths
    for (int k = 0; k < 1500; k++) begin
      int op;
      bit w;
      logic [63:0] a, b;
      op = int'($urandom % 4);
      w  = 1'($urandom);
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      runOp(w ? opReq(op) : "R9", op, w, a, b, int'($urandom % 64),
            int'($urandom % 64), (k % 50) == 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule